// File: doc/BRIEF.md
# JESD204 Link Reset Sequencer

This block distributes and orders the resets of a JESD204C-style transmit/receive subsystem. Three reset sources are merged into one management reset: an active-low push-button reset, an active-high software reset bit held in a control register, and an active-low control-block reset that comes from the register bridge. Once that merged reset has been released, a sequencer releases the other resets in a fixed order. The core PLL reset goes first, then the TX and RX register-interface resets, then the SYSREF-generator reset, and last the TX and RX link/transport resets. A programmable gap separates each step.

The SYSREF-generator reset waits for PLL lock. Each link reset also needs its own active-low acknowledge from the link layer. Loss of PLL lock pulls the SYSREF and link resets back at once and restarts the later part of the sequence.

Every reset output goes active asynchronously. Its release passes through a two-flop synchronizer clocked by the domain that uses it: the management clock, or the TX or RX link clock. The control-block reset is produced separately from the control-block reset input alone, so software and push-button resets can never clear the control logic that issues them.

Top module: `jlink_rst_seq`

## Requirements
- R1: `mgmt_rst_no` goes low at once while `rst_ni` is low, `sw_rst_i` is high or `ctl_rst_ni` is low. It returns high on the second `clk_i` rising edge after all three are inactive.
- R2: `ctl_rst_no` depends only on `ctl_rst_ni`. It goes low at once with it and returns high on the second `clk_i` edge after release. `rst_ni` and `sw_rst_i` have no effect on it.
- R3: `pll_rst_o` (active high) is 1 whenever `mgmt_rst_no` is low. It falls G+2 `clk_i` edges after `mgmt_rst_no` rises.
- R4: `tx_reg_rst_no` and `rx_reg_rst_no` are low whenever `mgmt_rst_no` is low. They rise exactly G cycles after `pll_rst_o` falls.
- R5: `sysref_rst_no` stays low while `pll_locked_i` is 0. With lock held, it rises exactly G cycles after the register resets rise.
- R6: `tx_link_rst_no` is high only while `pll_locked_i` is 1 and `tx_ack_ni` is 0. With both present, it rises exactly G cycles after `sysref_rst_no` rises.
- R7: `rx_link_rst_no` follows the rule in R6, using `rx_ack_ni`. A missing RX acknowledge does not hold back the TX link reset.
- R8: The gap G is `gap_i`, raised to 16 when `gap_i` is below 16. Releases happen in the order PLL, register, SYSREF, link, with exactly G cycles between successive steps.
- R9: A drop of `pll_locked_i` drives `sysref_rst_no` and both link resets low at once, while the register resets stay high. Once lock returns, the SYSREF and link releases run again, each G cycles after the previous step.
- R10: Raising one direction's acknowledge input (`tx_ack_ni` or `rx_ack_ni`) asserts only that direction's link reset, at once.
- R11: After its release condition becomes true, a link reset output rises on the second rising edge of its own link clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Management clock |
| rst_ni | input | 1 | Push-button global reset, active low |
| sw_rst_i | input | 1 | Software reset bit from the control register, active high |
| ctl_rst_ni | input | 1 | Bridge-driven control-block reset, active low |
| tx_link_clk_i | input | 1 | TX link clock |
| rx_link_clk_i | input | 1 | RX link clock |
| pll_locked_i | input | 1 | Core PLL lock indication |
| tx_ack_ni | input | 1 | TX reset acknowledge, active low |
| rx_ack_ni | input | 1 | RX reset acknowledge, active low |
| gap_i | input | GAP_W | Release spacing in management cycles (minimum MIN_GAP) |
| mgmt_rst_no | output | 1 | Merged management reset, active low |
| ctl_rst_no | output | 1 | Control-block reset, active low |
| pll_rst_o | output | 1 | Core PLL reset, active high |
| tx_reg_rst_no | output | 1 | TX register-interface reset, active low |
| rx_reg_rst_no | output | 1 | RX register-interface reset, active low |
| sysref_rst_no | output | 1 | SYSREF-generator reset, active low |
| tx_link_rst_no | output | 1 | TX link/transport reset, active low |
| rx_link_rst_no | output | 1 | RX link/transport reset, active low |

## Verification
The bench builds the block with its defaults: GAP_W = 8, MIN_GAP = 16 and a two-stage synchronizer. It ties both link clocks to the management clock, so that one cycle-accurate model can predict every output on every cycle. Driving `gap_i` with 0 and with 3 exercises the clamp to 16, and driving it with 20 checks a spacing above the minimum. Both give exact release distances that the bench measures. Lock drops, withdrawn acknowledges and each of the three reset sources are applied while the sequence is running, so re-entry into the sequence and isolation of the control reset are both checked.

// File: rtl/jrs_pkg.sv
package jrs_pkg;
  typedef enum logic [2:0] {
    ST_HOLD = 3'd0,
    ST_PLL  = 3'd1,
    ST_REG  = 3'd2,
    ST_SYS  = 3'd3,
    ST_LINK = 3'd4
  } stage_e;
endpackage

// File: rtl/jrs_rst_sync.sv
// Asynchronous assert, synchronous release reset cell.
module jrs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rel_i,
  output logic rst_no
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rel_i) begin
    if (!rel_i) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sh_q[STAGES-1];
endmodule

// File: rtl/jrs_gap_timer.sv
module jrs_gap_timer #(
  parameter int GAP_W   = 8,
  parameter int MIN_GAP = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             done_o
);
  localparam logic [GAP_W-1:0] MIN_V = GAP_W'(MIN_GAP);

  logic [GAP_W-1:0] cnt_q;
  logic [GAP_W-1:0] eff;

  assign eff    = (gap_i < MIN_V) ? MIN_V : gap_i;
  assign done_o = en_i && (cnt_q == eff - GAP_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || done_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + GAP_W'(1);
  end
endmodule

// File: rtl/jrs_seq_fsm.sv
module jrs_seq_fsm
  import jrs_pkg::*;
#(
  parameter int GAP_W   = 8,
  parameter int MIN_GAP = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             rel_pll_o,
  output logic             rel_reg_o,
  output logic             rel_sys_o,
  output logic             rel_link_o
);
  stage_e     stage_q, stage_d;
  logic [1:0] lk_q;
  logic       lock_s, tmr_en, tmr_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lk_q <= '0;
    else         lk_q <= {lk_q[0], lock_i};
  end
  assign lock_s = lk_q[1];

  // early steps count freely, later steps only while locked
  always_comb begin
    unique case (stage_q)
      ST_HOLD, ST_PLL: tmr_en = 1'b1;
      ST_REG, ST_SYS:  tmr_en = lock_s;
      default:         tmr_en = 1'b0;
    endcase
  end

  jrs_gap_timer #(.GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tmr_en),
    .gap_i  (gap_i),
    .done_o (tmr_done)
  );

  always_comb begin
    stage_d = stage_q;
    unique case (stage_q)
      ST_HOLD: if (tmr_done) stage_d = ST_PLL;
      ST_PLL:  if (tmr_done) stage_d = ST_REG;
      ST_REG:  if (tmr_done) stage_d = ST_SYS;
      ST_SYS: begin
        if (!lock_s)       stage_d = ST_REG;
        else if (tmr_done) stage_d = ST_LINK;
      end
      ST_LINK: if (!lock_s) stage_d = ST_REG;
      default: stage_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= ST_HOLD;
    else         stage_q <= stage_d;
  end

  assign rel_pll_o  = (stage_q != ST_HOLD);
  assign rel_reg_o  = (stage_q == ST_REG) || (stage_q == ST_SYS) || (stage_q == ST_LINK);
  assign rel_sys_o  = (stage_q == ST_SYS) || (stage_q == ST_LINK);
  assign rel_link_o = (stage_q == ST_LINK);
endmodule

// File: rtl/jlink_rst_seq.sv
module jlink_rst_seq #(
  parameter int GAP_W       = 8,
  parameter int MIN_GAP     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_rst_i,
  input  logic             ctl_rst_ni,
  input  logic             tx_link_clk_i,
  input  logic             rx_link_clk_i,
  input  logic             pll_locked_i,
  input  logic             tx_ack_ni,
  input  logic             rx_ack_ni,
  input  logic [GAP_W-1:0] gap_i,
  output logic             mgmt_rst_no,
  output logic             ctl_rst_no,
  output logic             pll_rst_o,
  output logic             tx_reg_rst_no,
  output logic             rx_reg_rst_no,
  output logic             sysref_rst_no,
  output logic             tx_link_rst_no,
  output logic             rx_link_rst_no
);
  localparam int NDIR = 2;

  logic any_rel, rel_pll, rel_reg, rel_sys, rel_link, pll_rst_n;
  logic [NDIR-1:0] lclk, ack_n, link_rst_n, reg_rst_n;

  assign any_rel = rst_ni && !sw_rst_i && ctl_rst_ni;

  jrs_rst_sync #(.STAGES(SYNC_STAGES)) u_mgmt_sync (
    .clk_i(clk_i), .rel_i(any_rel), .rst_no(mgmt_rst_no));

  // control-block reset sees only its own source
  jrs_rst_sync #(.STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk_i(clk_i), .rel_i(ctl_rst_ni), .rst_no(ctl_rst_no));

  jrs_seq_fsm #(.GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (mgmt_rst_no),
    .lock_i     (pll_locked_i),
    .gap_i      (gap_i),
    .rel_pll_o  (rel_pll),
    .rel_reg_o  (rel_reg),
    .rel_sys_o  (rel_sys),
    .rel_link_o (rel_link)
  );

  jrs_rst_sync #(.STAGES(SYNC_STAGES)) u_pll_sync (
    .clk_i(clk_i), .rel_i(rel_pll), .rst_no(pll_rst_n));
  assign pll_rst_o = !pll_rst_n;

  // raw lock on the clear path so loss of lock acts without delay
  jrs_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk_i(clk_i), .rel_i(rel_sys && pll_locked_i), .rst_no(sysref_rst_no));

  assign lclk  = {rx_link_clk_i, tx_link_clk_i};
  assign ack_n = {rx_ack_ni, tx_ack_ni};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    jrs_rst_sync #(.STAGES(SYNC_STAGES)) u_reg_sync (
      .clk_i(clk_i), .rel_i(rel_reg), .rst_no(reg_rst_n[d]));
    jrs_rst_sync #(.STAGES(SYNC_STAGES)) u_link_sync (
      .clk_i  (lclk[d]),
      .rel_i  (rel_link && pll_locked_i && !ack_n[d]),
      .rst_no (link_rst_n[d]));
  end

  assign tx_reg_rst_no  = reg_rst_n[0];
  assign rx_reg_rst_no  = reg_rst_n[1];
  assign tx_link_rst_no = link_rst_n[0];
  assign rx_link_rst_no = link_rst_n[1];
endmodule

// File: rtl/jrs_chk.sv
module jrs_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sw_rst_i,
  input logic ctl_rst_ni,
  input logic pll_locked_i,
  input logic tx_ack_ni,
  input logic rx_ack_ni,
  input logic mgmt_rst_no,
  input logic pll_rst_o,
  input logic tx_reg_rst_no,
  input logic rx_reg_rst_no,
  input logic sysref_rst_no,
  input logic tx_link_rst_no,
  input logic rx_link_rst_no
);
  // R1
  mgmt_merge_chk: assert property (@(posedge clk_i) disable iff (!ctl_rst_ni)
    (!rst_ni || sw_rst_i) |-> !mgmt_rst_no);
  // R3
  pll_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mgmt_rst_no |-> pll_rst_o);
  // R4
  reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mgmt_rst_no |-> (!tx_reg_rst_no && !rx_reg_rst_no));
  // R5
  sysref_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_locked_i |-> !sysref_rst_no);
  // R6
  tx_link_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ack_ni || !pll_locked_i) |-> !tx_link_rst_no);
  // R7
  rx_link_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ack_ni || !pll_locked_i) |-> !rx_link_rst_no);
  // R8
  sys_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysref_rst_no |-> (tx_reg_rst_no && rx_reg_rst_no && !pll_rst_o));
  // R8
  link_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_link_rst_no || rx_link_rst_no) |-> sysref_rst_no);
endmodule

bind jlink_rst_seq jrs_chk chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sw_rst_i       (sw_rst_i),
  .ctl_rst_ni     (ctl_rst_ni),
  .pll_locked_i   (pll_locked_i),
  .tx_ack_ni      (tx_ack_ni),
  .rx_ack_ni      (rx_ack_ni),
  .mgmt_rst_no    (mgmt_rst_no),
  .pll_rst_o      (pll_rst_o),
  .tx_reg_rst_no  (tx_reg_rst_no),
  .rx_reg_rst_no  (rx_reg_rst_no),
  .sysref_rst_no  (sysref_rst_no),
  .tx_link_rst_no (tx_link_rst_no),
  .rx_link_rst_no (rx_link_rst_no)
);

// File: tb/jlink_rst_seq_tb_top.sv
`timescale 1ns/1ps
module jlink_rst_seq_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni = 1'b1, sw_rst_i = 1'b0, ctl_rst_ni = 1'b1, pll_locked_i = 1'b0;
  logic tx_ack_ni = 1'b1, rx_ack_ni = 1'b1;
  logic [7:0] gap_i = 8'd0;
  logic mgmt_rst_no, ctl_rst_no, pll_rst_o, tx_reg_rst_no, rx_reg_rst_no;
  logic sysref_rst_no, tx_link_rst_no, rx_link_rst_no;

  jlink_rst_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sw_rst_i(sw_rst_i), .ctl_rst_ni(ctl_rst_ni),
    .tx_link_clk_i(clk), .rx_link_clk_i(clk), .pll_locked_i(pll_locked_i),
    .tx_ack_ni(tx_ack_ni), .rx_ack_ni(rx_ack_ni), .gap_i(gap_i),
    .mgmt_rst_no(mgmt_rst_no), .ctl_rst_no(ctl_rst_no), .pll_rst_o(pll_rst_o),
    .tx_reg_rst_no(tx_reg_rst_no), .rx_reg_rst_no(rx_reg_rst_no),
    .sysref_rst_no(sysref_rst_no), .tx_link_rst_no(tx_link_rst_no),
    .rx_link_rst_no(rx_link_rst_no));

  int nchk = 0, nbad = 0, cyc = 0;
  bit finished = 0;

  // behavioural reference: stage 0 hold,1 pll,2 reg,3 sysref,4 link
  int m0 = 0, m1 = 0, c0 = 0, c1 = 0, l0 = 0, l1 = 0, stg = 0, cnt = 0;
  int s0[6] = '{default: 0};
  int s1[6] = '{default: 0};

  function automatic int any_rel();
    return (rst_ni && !sw_rst_i && ctl_rst_ni) ? 1 : 0;
  endfunction

  function automatic int mreq(int k);
    case (k)
      0:       return (stg >= 1) ? 1 : 0;
      1, 2:    return (stg >= 2) ? 1 : 0;
      3:       return (stg >= 3 && pll_locked_i) ? 1 : 0;
      4:       return (stg == 4 && pll_locked_i && !tx_ack_ni) ? 1 : 0;
      default: return (stg == 4 && pll_locked_i && !rx_ack_ni) ? 1 : 0;
    endcase
  endfunction

  task automatic m_async();
    if (!any_rel()) begin m0 = 0; m1 = 0; end
    if (!ctl_rst_ni) begin c0 = 0; c1 = 0; end
    if (m1 == 0) begin stg = 0; cnt = 0; l0 = 0; l1 = 0; end
    for (int k = 0; k < 6; k++) if (!mreq(k)) begin s0[k] = 0; s1[k] = 0; end
  endtask

  always @(posedge clk) begin
    int n_stg, n_cnt, eff, en, done;
    int r[6];
    m_async();
    for (int k = 0; k < 6; k++) r[k] = mreq(k);
    n_stg = stg; n_cnt = cnt;
    if (m1 != 0) begin
      eff  = (gap_i < 16) ? 16 : int'(gap_i);
      en   = (stg <= 1) || ((stg == 2 || stg == 3) && l1 != 0);
      done = en && (cnt == eff - 1);
      n_cnt = (!en || done) ? 0 : cnt + 1;
      if (stg == 3 && l1 == 0) n_stg = 2;
      else if (stg == 4 && l1 == 0) n_stg = 2;
      else if (done && stg < 4) n_stg = stg + 1;
      l1 = l0; l0 = pll_locked_i;
    end
    stg = n_stg; cnt = n_cnt;
    if (any_rel()) begin m1 = m0; m0 = 1; end
    if (ctl_rst_ni) begin c1 = c0; c0 = 1; end
    for (int k = 0; k < 6; k++) if (r[k] != 0) begin s1[k] = s0[k]; s0[k] = 1; end
    m_async();
  end

  task automatic ck(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic cmp();
    m_async();
    ck("R1 mgmt_rst_no", int'(mgmt_rst_no), m1);
    ck("R2 ctl_rst_no", int'(ctl_rst_no), c1);
    ck("R3 pll_rst_o", int'(pll_rst_o), s1[0] ? 0 : 1);
    ck("R4 tx_reg_rst_no", int'(tx_reg_rst_no), s1[1]);
    ck("R4 rx_reg_rst_no", int'(rx_reg_rst_no), s1[2]);
    ck("R5 sysref_rst_no", int'(sysref_rst_no), s1[3]);
    ck("R6 tx_link_rst_no", int'(tx_link_rst_no), s1[4]);
    ck("R7 rx_link_rst_no", int'(rx_link_rst_no), s1[5]);
  endtask

  int t_mgmt, t_pll, t_reg, t_sys, t_tx, t_rx;
  logic p_mgmt = 0, p_pll = 1, p_reg = 0, p_sys = 0, p_tx = 0, p_rx = 0;

  task automatic tick();
    @(negedge clk);
    cyc++;
    cmp();
    if (mgmt_rst_no && !p_mgmt) t_mgmt = cyc;
    if (!pll_rst_o && p_pll) t_pll = cyc;
    if (tx_reg_rst_no && !p_reg) t_reg = cyc;
    if (sysref_rst_no && !p_sys) t_sys = cyc;
    if (tx_link_rst_no && !p_tx) t_tx = cyc;
    if (rx_link_rst_no && !p_rx) t_rx = cyc;
    p_mgmt = mgmt_rst_no; p_pll = pll_rst_o; p_reg = tx_reg_rst_no;
    p_sys = sysref_rst_no; p_tx = tx_link_rst_no; p_rx = rx_link_rst_no;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic now_chk();
    #1 cmp();
  endtask

  task automatic gaps_chk(int g);
    ck("R3 pll after mgmt", t_pll - t_mgmt, g + 2);
    ck("R8 reg after pll", t_reg - t_pll, g);
    ck("R8 sysref after reg", t_sys - t_reg, g);
    ck("R8 link after sysref", t_tx - t_sys, g);
  endtask

  initial begin
    #1 rst_ni = 1'b0; ctl_rst_ni = 1'b0;
    run(3);
    // reset state
    ck("R1 reset mgmt", int'(mgmt_rst_no), 0);
    ck("R2 reset ctl", int'(ctl_rst_no), 0);
    ck("R3 reset pll", int'(pll_rst_o), 1);
    ck("R4 reset reg", int'(tx_reg_rst_no | rx_reg_rst_no), 0);
    // power-up sequence, gap 0 clamps to 16
    rst_ni = 1'b1; ctl_rst_ni = 1'b1; pll_locked_i = 1'b1;
    tx_ack_ni = 1'b0; rx_ack_ni = 1'b0;
    run(90);
    gaps_chk(16);
    ck("R7 rx with tx", t_rx, t_tx);
    // lock loss
    pll_locked_i = 1'b0; now_chk();
    ck("R9 sysref drops", int'(sysref_rst_no), 0);
    ck("R9 links drop", int'(tx_link_rst_no | rx_link_rst_no), 0);
    ck("R9 reg kept", int'(tx_reg_rst_no), 1);
    run(5);
    pll_locked_i = 1'b1;
    run(60);
    ck("R9 relink", int'(tx_link_rst_no & rx_link_rst_no), 1);
    ck("R9 relink spacing", t_tx - t_sys, 16);
    // tx ack withdrawal
    tx_ack_ni = 1'b1; now_chk();
    ck("R10 tx drops", int'(tx_link_rst_no), 0);
    ck("R10 rx kept", int'(rx_link_rst_no), 1);
    run(4);
    tx_ack_ni = 1'b0;
    tick();
    ck("R11 one edge", int'(tx_link_rst_no), 0);
    tick();
    ck("R11 two edges", int'(tx_link_rst_no), 1);
    // software reset, rx acknowledge late, gap 20
    sw_rst_i = 1'b1; now_chk();
    ck("R1 sw mgmt", int'(mgmt_rst_no), 0);
    ck("R2 sw ctl kept", int'(ctl_rst_no), 1);
    ck("R3 sw pll", int'(pll_rst_o), 1);
    run(3);
    gap_i = 8'd20; rx_ack_ni = 1'b1;
    sw_rst_i = 1'b0;
    run(100);
    gaps_chk(20);
    ck("R7 rx held", int'(rx_link_rst_no), 0);
    ck("R7 tx free", int'(tx_link_rst_no), 1);
    rx_ack_ni = 1'b0;
    run(3);
    ck("R7 rx released", int'(rx_link_rst_no), 1);
    // global reset, lock absent
    rst_ni = 1'b0; now_chk();
    ck("R1 global mgmt", int'(mgmt_rst_no), 0);
    ck("R2 global ctl kept", int'(ctl_rst_no), 1);
    run(2);
    pll_locked_i = 1'b0; gap_i = 8'd16;
    rst_ni = 1'b1;
    run(80);
    ck("R5 no lock sysref", int'(sysref_rst_no), 0);
    ck("R5 no lock reg", int'(tx_reg_rst_no), 1);
    pll_locked_i = 1'b1;
    run(60);
    ck("R6 after lock", int'(tx_link_rst_no), 1);
    // control-block reset, gap 3 clamps
    ctl_rst_ni = 1'b0; gap_i = 8'd3; now_chk();
    ck("R1 ctl mgmt", int'(mgmt_rst_no), 0);
    ck("R2 ctl low", int'(ctl_rst_no), 0);
    run(2);
    ctl_rst_ni = 1'b1;
    run(100);
    gaps_chk(16);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule